// File: doc/BRIEF.md
# Address-Space-Steered Two-Way Data Cache

This block is a small set-associative data cache that sits between a processor load/store port and a single-word main-memory port. Every access brings a 32-bit address and an 8-bit address-space code. The low four bits of that code choose how the access is treated. It can be an ordinary cached access, a forced memory access that may allocate, or a forced memory access that only refreshes lines already held. It can also be a whole-cache invalidation, or a diagnostic read or write of the tag or data store.

A fixed address map makes two regions cacheable and the rest uncacheable. The cache has two ways of sixteen one-word lines. Replacement uses one least-recently-used bit per set. Stores write through to memory and never allocate. The processor starts an access by raising `req_valid` while `busy` is low. It then waits for the one-cycle `resp_valid` pulse, which carries the load data. Memory accesses and the invalidation walk keep `busy` high until that pulse.

Top module: `asi_dcache`

## Requirements
- R1: After reset, `busy`, `resp_valid` and `mem_req` are low and every line is invalid, so the first load to any address goes to memory.
- R2: Only addresses 0x00000000–0x1FFFFFFF and 0x40000000–0x7FFFFFFF can be held in the cache. A load to any other address reaches memory every time and never fills a line.
- R3: Only bits [3:0] of `req_space` are decoded. Bits [7:4] have no effect on behaviour.
- R4: An access is accepted on a rising edge where `req_valid` is high and `busy` is low. A normal load that hits (space low nibble 0x8–0xB) raises `resp_valid` for one cycle at the second rising edge after acceptance, with the cached word and no memory access.
- R5: A normal load that misses a cacheable address reads memory and fills a line, so the next normal load to it hits.
- R6: Codes 0x0–0x3 always read memory, even on a tag hit. A held line takes the new memory word. An absent cacheable line is allocated.
- R7: Codes 0x4 and 0x7 always read memory. They refresh a line that is already held and never allocate one.
- R8: Code 0x6 invalidates every line. It clears one set per cycle and raises `resp_valid` SETS+2 rising edges after acceptance, with no memory access.
- R9: Codes 0x5, 0xC and 0xD complete in two cycles without a memory access and leave the cache contents unchanged.
- R10: Code 0xE reads or writes the tag store. Address bit 6 picks the way and bits [5:2] pick the set. A read returns the valid bit in bit 31, zeros in bits 30:26 and the tag in bits 25:0. A write takes the tag from `req_wdata[25:0]` and the valid bit from `req_wdata[31]`.
- R11: Code 0xF reads or writes the data word of the line chosen by the same way and set selection as R10, with no memory access.
- R12: Each set keeps one bit naming the way not used last. Every hit and every fill updates it, and an allocation replaces the way it names.
- R13: Every store is written to memory with its address and data. A store that hits also updates the cached word. A store that misses allocates nothing.
- R14: `mem_req` is held with a stable address, direction and write data until `mem_ack`. `resp_valid` follows at the next rising edge after the acknowledged edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address (word aligned) |
| req_space | input | 8 | Address-space code; bits [3:0] used |
| req_wdata | input | 32 | Store or diagnostic write data |
| busy | output | 1 | Access in progress; new requests are not taken |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load or diagnostic read data |
| mem_req | output | 1 | Memory access request |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
The hardest case to reach is replacement that depends on LRU history. The bench fills both ways of one set and hits the older line to move the LRU bit. A third tag is then loaded into the same set. A diagnostic tag read confirms which way was overwritten, and memory-access counts show which line survived. Refreshes of lines already held can only be seen after the memory contents change. The bench therefore alters its memory model between a forced access and the normal load that follows it.

// File: rtl/asi_dc_pkg.sv
package asi_dc_pkg;

  typedef enum logic [2:0] {
    AC_NORMAL,
    AC_ALLOC,
    AC_UPDATE,
    AC_FLUSH,
    AC_TAGDIAG,
    AC_DATADIAG,
    AC_NOP
  } acc_class_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MEM,
    ST_FLUSH,
    ST_RESP
  } dc_state_e;

  // Fixed address map: low boot region and main RAM region are cacheable.
  function automatic logic addr_cacheable(input logic [31:0] a);
    return (a[31:29] == 3'b000) || (a[31:30] == 2'b01);
  endfunction

endpackage

// File: rtl/asi_dc_decode.sv
module asi_dc_decode
  import asi_dc_pkg::*;
(
  input  logic [7:0]  space,
  input  logic [31:0] addr,
  output acc_class_e  cls,
  output logic        cacheable
);

  always_comb begin
    unique case (space[3:0])
      4'h0, 4'h1, 4'h2, 4'h3: cls = AC_ALLOC;
      4'h4, 4'h7:             cls = AC_UPDATE;
      4'h6:                   cls = AC_FLUSH;
      4'h8, 4'h9, 4'hA, 4'hB: cls = AC_NORMAL;
      4'hE:                   cls = AC_TAGDIAG;
      4'hF:                   cls = AC_DATADIAG;
      default:                cls = AC_NOP;
    endcase
  end

  assign cacheable = addr_cacheable(addr);

endmodule

// File: rtl/asi_dc_array.sv
module asi_dc_array #(
  parameter int SETS   = 16,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 26,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [WAYS-1:0]              rd_valid,
  output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
  output logic [WAYS-1:0][DATA_W-1:0]  rd_data,
  output logic [WAY_W-1:0]             rd_lru,
  input  logic                         we_tag,
  input  logic                         we_valid,
  input  logic                         we_data,
  input  logic                         wr_valid_val,
  input  logic [WAY_W-1:0]             wr_way,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         clr_en,
  input  logic [IDX_W-1:0]             clr_idx,
  input  logic                         lru_we,
  input  logic [WAY_W-1:0]             lru_val
);

  logic [SETS-1:0][WAY_W-1:0] lru_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]             valid_q;
    logic [TAG_W-1:0]            tag_q  [SETS];
    logic [DATA_W-1:0]           data_q [SETS];
    logic                        sel;

    assign sel = (wr_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= '0;
      end else begin
        if (clr_en) begin
          valid_q[clr_idx] <= 1'b0;
        end else if (we_valid && sel) begin
          valid_q[wr_idx] <= wr_valid_val;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (we_tag && sel) begin
        tag_q[wr_idx] <= wr_tag;
      end
      if (we_data && sel) begin
        data_q[wr_idx] <= wr_data;
      end
    end

    assign rd_valid[w] = valid_q[rd_idx];
    assign rd_tag[w]   = tag_q[rd_idx];
    assign rd_data[w]  = data_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else if (lru_we) begin
      lru_q[wr_idx] <= lru_val;
    end
  end

  assign rd_lru = lru_q[rd_idx];

endmodule

// File: rtl/asi_dc_ctrl.sv
module asi_dc_ctrl
  import asi_dc_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int OFF_W = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [DATA_W-1:0]            req_wdata,
  input  acc_class_e                   req_cls,
  input  logic                         req_cacheable,
  output logic                         busy,
  output logic                         resp_valid,
  output logic [DATA_W-1:0]            resp_rdata,
  output logic                         mem_req,
  output logic                         mem_write,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic                         mem_ack,
  input  logic [DATA_W-1:0]            mem_rdata,
  output logic [IDX_W-1:0]             rd_idx,
  input  logic [WAYS-1:0]              rd_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
  input  logic [WAYS-1:0][DATA_W-1:0]  rd_data,
  input  logic [WAY_W-1:0]             rd_lru,
  output logic                         we_tag,
  output logic                         we_valid,
  output logic                         we_data,
  output logic                         wr_valid_val,
  output logic [WAY_W-1:0]             wr_way,
  output logic [IDX_W-1:0]             wr_idx,
  output logic [TAG_W-1:0]             wr_tag,
  output logic [DATA_W-1:0]            wr_data,
  output logic                         clr_en,
  output logic [IDX_W-1:0]             clr_idx,
  output logic                         lru_we,
  output logic [WAY_W-1:0]             lru_val
);

  dc_state_e         state_q, state_d;
  logic [IDX_W-1:0]  fcnt_q, fcnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  acc_class_e        cls_q;
  logic              cacheable_q;
  logic              hit_q;
  logic [WAY_W-1:0]  hway_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              cap_en, rdata_en, look_en;

  logic              hit;
  logic [WAY_W-1:0]  hway;
  logic [TAG_W-1:0]  addr_tag;
  logic [WAY_W-1:0]  diag_way;

  assign addr_tag = addr_q[ADDR_W-1 -: TAG_W];
  assign diag_way = addr_q[IDX_W+OFF_W +: WAY_W];
  assign rd_idx   = addr_q[OFF_W +: IDX_W];

  // Tag compare across all ways
  always_comb begin
    hit  = 1'b0;
    hway = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (cacheable_q && rd_valid[w] && (rd_tag[w] == addr_tag)) begin
        hit  = 1'b1;
        hway = WAY_W'(w);
      end
    end
  end

  // Next-state and array control
  always_comb begin
    state_d      = state_q;
    fcnt_d       = fcnt_q;
    rdata_d      = rdata_q;
    cap_en       = 1'b0;
    rdata_en     = 1'b0;
    look_en      = 1'b0;
    we_tag       = 1'b0;
    we_valid     = 1'b0;
    we_data      = 1'b0;
    wr_valid_val = 1'b0;
    wr_way       = hway_q;
    wr_idx       = rd_idx;
    wr_tag       = addr_tag;
    wr_data      = wdata_q;
    clr_en       = 1'b0;
    clr_idx      = fcnt_q;
    lru_we       = 1'b0;
    lru_val      = ~hway_q;

    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          state_d = ST_LOOK;
        end
      end

      ST_LOOK: begin
        look_en = 1'b1;
        unique case (cls_q)
          AC_NORMAL: begin
            if (!write_q && hit) begin
              rdata_en = 1'b1;
              rdata_d  = rd_data[hway];
              lru_we   = 1'b1;
              wr_way   = hway;
              lru_val  = ~hway;
              state_d  = ST_RESP;
            end else begin
              state_d  = ST_MEM;
            end
          end
          AC_ALLOC, AC_UPDATE: state_d = ST_MEM;
          AC_FLUSH: begin
            fcnt_d  = '0;
            state_d = ST_FLUSH;
          end
          AC_TAGDIAG: begin
            if (write_q) begin
              we_tag       = 1'b1;
              we_valid     = 1'b1;
              wr_valid_val = wdata_q[DATA_W-1];
              wr_way       = diag_way;
              wr_tag       = wdata_q[TAG_W-1:0];
            end else begin
              rdata_en = 1'b1;
              rdata_d  = {rd_valid[diag_way], {(DATA_W-TAG_W-1){1'b0}}, rd_tag[diag_way]};
            end
            state_d = ST_RESP;
          end
          AC_DATADIAG: begin
            if (write_q) begin
              we_data = 1'b1;
              wr_way  = diag_way;
            end else begin
              rdata_en = 1'b1;
              rdata_d  = rd_data[diag_way];
            end
            state_d = ST_RESP;
          end
          default: state_d = ST_RESP;
        endcase
      end

      ST_MEM: begin
        if (mem_ack) begin
          state_d = ST_RESP;
          if (write_q) begin
            if (hit_q) begin
              we_data = 1'b1;
              lru_we  = 1'b1;
            end
          end else begin
            rdata_en = 1'b1;
            rdata_d  = mem_rdata;
            wr_data  = mem_rdata;
            if (hit_q && (cls_q != AC_NORMAL)) begin
              we_data = 1'b1;
              lru_we  = 1'b1;
            end else if (!hit_q && cacheable_q &&
                         ((cls_q == AC_NORMAL) || (cls_q == AC_ALLOC))) begin
              we_tag       = 1'b1;
              we_valid     = 1'b1;
              wr_valid_val = 1'b1;
              we_data      = 1'b1;
              wr_way       = rd_lru;
              lru_we       = 1'b1;
              lru_val      = ~rd_lru;
            end
          end
        end
      end

      ST_FLUSH: begin
        clr_en = 1'b1;
        if (fcnt_q == IDX_W'(SETS-1)) begin
          state_d = ST_RESP;
        end else begin
          fcnt_d = fcnt_q + 1'b1;
        end
      end

      ST_RESP: state_d = ST_IDLE;

      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      fcnt_q  <= fcnt_d;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q      <= req_addr;
      wdata_q     <= req_wdata;
      write_q     <= req_write;
      cls_q       <= req_cls;
      cacheable_q <= req_cacheable;
    end
    if (look_en) begin
      hit_q  <= hit;
      hway_q <= hway;
    end
    if (rdata_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign resp_valid = (state_q == ST_RESP);
  assign resp_rdata = rdata_q;
  assign mem_req    = (state_q == ST_MEM);
  assign mem_write  = write_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;

endmodule

// File: rtl/asi_dcache.sv
module asi_dcache
  import asi_dc_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int WAYS   = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W = ADDR_W - IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [31:0]       req_addr,
  input  logic [7:0]        req_space,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              resp_valid,
  output logic [31:0]       resp_rdata,
  output logic              mem_req,
  output logic              mem_write,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata
);

  acc_class_e                 dec_cls;
  logic                       dec_cacheable;
  logic [IDX_W-1:0]           arr_rd_idx;
  logic [WAYS-1:0]            arr_valid;
  logic [WAYS-1:0][TAG_W-1:0] arr_tag;
  logic [WAYS-1:0][DATA_W-1:0] arr_data;
  logic [WAY_W-1:0]           arr_lru;
  logic                       arr_we_tag, arr_we_valid, arr_we_data, arr_valid_val;
  logic [WAY_W-1:0]           arr_way;
  logic [IDX_W-1:0]           arr_wr_idx;
  logic [TAG_W-1:0]           arr_wr_tag;
  logic [DATA_W-1:0]          arr_wr_data;
  logic                       arr_clr_en;
  logic [IDX_W-1:0]           arr_clr_idx;
  logic                       arr_lru_we;
  logic [WAY_W-1:0]           arr_lru_val;

  asi_dc_decode u_decode (
    .space     (req_space),
    .addr      (req_addr),
    .cls       (dec_cls),
    .cacheable (dec_cacheable)
  );

  asi_dc_ctrl #(
    .SETS(SETS), .WAYS(WAYS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .req_cls       (dec_cls),
    .req_cacheable (dec_cacheable),
    .busy          (busy),
    .resp_valid    (resp_valid),
    .resp_rdata    (resp_rdata),
    .mem_req       (mem_req),
    .mem_write     (mem_write),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .rd_idx        (arr_rd_idx),
    .rd_valid      (arr_valid),
    .rd_tag        (arr_tag),
    .rd_data       (arr_data),
    .rd_lru        (arr_lru),
    .we_tag        (arr_we_tag),
    .we_valid      (arr_we_valid),
    .we_data       (arr_we_data),
    .wr_valid_val  (arr_valid_val),
    .wr_way        (arr_way),
    .wr_idx        (arr_wr_idx),
    .wr_tag        (arr_wr_tag),
    .wr_data       (arr_wr_data),
    .clr_en        (arr_clr_en),
    .clr_idx       (arr_clr_idx),
    .lru_we        (arr_lru_we),
    .lru_val       (arr_lru_val)
  );

  asi_dc_array #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_array (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_idx       (arr_rd_idx),
    .rd_valid     (arr_valid),
    .rd_tag       (arr_tag),
    .rd_data      (arr_data),
    .rd_lru       (arr_lru),
    .we_tag       (arr_we_tag),
    .we_valid     (arr_we_valid),
    .we_data      (arr_we_data),
    .wr_valid_val (arr_valid_val),
    .wr_way       (arr_way),
    .wr_idx       (arr_wr_idx),
    .wr_tag       (arr_wr_tag),
    .wr_data      (arr_wr_data),
    .clr_en       (arr_clr_en),
    .clr_idx      (arr_clr_idx),
    .lru_we       (arr_lru_we),
    .lru_val      (arr_lru_val)
  );

endmodule

// File: rtl/asi_dcache_chk.sv
module asi_dcache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        resp_valid,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        arr_we_tag
);

  // R14
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

  // R14
  mem_ack_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (resp_valid && !mem_req));

  // R4
  resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R2
  fill_cacheable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_tag && mem_req) |-> ((mem_addr[31:29] == 3'b000) || (mem_addr[31:30] == 2'b01)));

endmodule

bind asi_dcache asi_dcache_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .busy       (busy),
  .resp_valid (resp_valid),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_write  (mem_write),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .arr_we_tag (arr_we_tag)
);

// File: tb/asi_dcache_tb.sv
module asi_dcache_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [7:0]  req_space = '0;
  logic        busy, resp_valid, mem_req, mem_write;
  logic [31:0] resp_rdata, mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0, cyc = 0;
  int mem_cnt = 0, pend = 0;
  logic [31:0] salt = '0;
  logic [31:0] last_wr_addr = '0, last_wr_data = '0;

  always #2 clk = ~clk;

  asi_dcache u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_space(req_space), .req_wdata(req_wdata),
    .busy(busy), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mval(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A00_00C3 ^ salt;
  endfunction

  // Memory model: acknowledges on the second falling edge of a request
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        pend++;
        if (pend >= 2) begin
          mem_ack   = 1'b1;
          mem_rdata = mval(mem_addr);
          mem_cnt++;
          pend = 0;
          if (mem_write) begin
            last_wr_addr = mem_addr;
            last_wr_data = mem_wdata;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [31:0] a, input logic [7:0] sp,
                     input logic [31:0] wd, output logic [31:0] rd,
                     output int lat, output int nm);
    int m0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_space = sp; req_wdata = wd;
    m0 = mem_cnt;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid) begin
      @(negedge clk);
      lat++;
    end
    rd = resp_rdata;
    nm = mem_cnt - m0;
  endtask

  logic [31:0] rd;
  int lat, nm;

  localparam logic [31:0] A  = 32'h4000_0010;
  localparam logic [31:0] L0 = 32'h4000_0014;
  localparam logic [31:0] L1 = 32'h4000_0054;
  localparam logic [31:0] L2 = 32'h4000_0094;
  localparam logic [31:0] D  = 32'h0000_0100;
  localparam logic [31:0] E  = 32'h4000_0200;
  localparam logic [31:0] F  = 32'h4000_0300;

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 resp_valid", {31'b0, resp_valid}, 0);
    chk("R1 mem_req", {31'b0, mem_req}, 0);
  endtask

  task automatic t_normal();
    acc(0, A, 8'h08, 0, rd, lat, nm);
    chk("R1 first load misses", nm, 1);
    chk("R5 miss data", rd, mval(A));
    chk("R14 miss latency", lat, 4);
    acc(0, A, 8'h0B, 0, rd, lat, nm);
    chk("R5 refill hit", nm, 0);
    chk("R4 hit latency", lat, 2);
    chk("R4 hit data", rd, mval(A));
  endtask

  task automatic t_upper();
    acc(0, A, 8'hF9, 0, rd, lat, nm);
    chk("R3 upper bits ignored", nm, 0);
    chk("R3 data", rd, mval(A));
  endtask

  task automatic t_map();
    acc(0, 32'h2000_0010, 8'h08, 0, rd, lat, nm);
    acc(0, 32'h2000_0010, 8'h08, 0, rd, lat, nm);
    chk("R2 io region not cached", nm, 1);
    acc(0, 32'h9000_0000, 8'h08, 0, rd, lat, nm);
    acc(0, 32'h9000_0000, 8'h08, 0, rd, lat, nm);
    chk("R2 high region not cached", nm, 1);
    acc(0, 32'h1FFF_FFFC, 8'h08, 0, rd, lat, nm);
    acc(0, 32'h1FFF_FFFC, 8'h08, 0, rd, lat, nm);
    chk("R2 boot region cached", nm, 0);
  endtask

  task automatic t_lru();
    acc(0, L0, 8'h08, 0, rd, lat, nm);
    acc(0, L1, 8'h08, 0, rd, lat, nm);
    acc(0, L0, 8'h08, 0, rd, lat, nm);
    chk("R12 both ways held", nm, 0);
    acc(0, L2, 8'h08, 0, rd, lat, nm);
    acc(0, L0, 8'h08, 0, rd, lat, nm);
    chk("R12 recent line kept", nm, 0);
    acc(0, 32'h0000_0054, 8'h0E, 0, rd, lat, nm);
    chk("R10 R12 way1 holds new tag", rd, 32'h8000_0000 | (L2 >> 6));
    acc(0, L1, 8'h08, 0, rd, lat, nm);
    chk("R12 older line evicted", nm, 1);
  endtask

  task automatic t_forced();
    salt = 32'h0000_1111;
    acc(0, A, 8'h02, 0, rd, lat, nm);
    chk("R6 forced access on hit", nm, 1);
    chk("R6 forced data", rd, mval(A));
    acc(0, A, 8'h08, 0, rd, lat, nm);
    chk("R6 line refreshed", rd, mval(A));
    chk("R6 refresh then hit", nm, 0);
    acc(0, D, 8'h00, 0, rd, lat, nm);
    acc(0, D, 8'h08, 0, rd, lat, nm);
    chk("R6 absent line allocated", nm, 0);
  endtask

  task automatic t_update();
    acc(0, E, 8'h04, 0, rd, lat, nm);
    chk("R7 goes to memory", nm, 1);
    acc(0, E, 8'h07, 0, rd, lat, nm);
    chk("R7 no allocate", nm, 1);
    acc(0, E, 8'h08, 0, rd, lat, nm);
    chk("R7 still absent", nm, 1);
    salt = 32'h0000_2222;
    acc(0, E, 8'h07, 0, rd, lat, nm);
    chk("R7 forced on hit", nm, 1);
    acc(0, E, 8'h08, 0, rd, lat, nm);
    chk("R7 refreshed data", rd, mval(E));
    chk("R7 refreshed hit", nm, 0);
  endtask

  task automatic t_store();
    acc(0, A, 8'h08, 0, rd, lat, nm);
    acc(1, A, 8'h08, 32'hCAFE_0001, rd, lat, nm);
    chk("R13 store to memory", nm, 1);
    chk("R13 store addr", last_wr_addr, A);
    chk("R13 store data", last_wr_data, 32'hCAFE_0001);
    acc(0, A, 8'h08, 0, rd, lat, nm);
    chk("R13 hit updated", rd, 32'hCAFE_0001);
    chk("R13 hit no memory", nm, 0);
    acc(1, F, 8'h08, 32'h0BAD_F00D, rd, lat, nm);
    acc(0, F, 8'h08, 0, rd, lat, nm);
    chk("R13 no write allocate", nm, 1);
  endtask

  task automatic t_diag();
    acc(1, 32'h0000_0024, 8'h0E, 32'h8100_0000, rd, lat, nm);
    acc(1, 32'h0000_0024, 8'h0F, 32'hDEAD_BEEF, rd, lat, nm);
    chk("R11 diag no memory", nm, 0);
    acc(0, 32'h4000_0024, 8'h08, 0, rd, lat, nm);
    chk("R10 planted tag hits", nm, 0);
    chk("R11 planted data", rd, 32'hDEAD_BEEF);
    acc(0, 32'h0000_0024, 8'h0F, 0, rd, lat, nm);
    chk("R11 diag data read", rd, 32'hDEAD_BEEF);
    acc(0, 32'h0000_0024, 8'h0E, 0, rd, lat, nm);
    chk("R10 diag tag read", rd, 32'h8100_0000);
    acc(1, 32'h0000_0024, 8'h0E, 32'h0100_0000, rd, lat, nm);
    acc(0, 32'h4000_0024, 8'h08, 0, rd, lat, nm);
    chk("R10 cleared valid misses", nm, 1);
  endtask

  task automatic t_nop();
    acc(0, A, 8'h05, 0, rd, lat, nm);
    chk("R9 code 5 latency", lat, 2);
    chk("R9 code 5 no memory", nm, 0);
    acc(0, A, 8'h0C, 0, rd, lat, nm);
    acc(1, A, 8'h0D, 32'h1234_5678, rd, lat, nm);
    chk("R9 codes C D no memory", nm, 0);
    acc(0, A, 8'h08, 0, rd, lat, nm);
    chk("R9 cache unchanged", rd, 32'hCAFE_0001);
    chk("R9 still hit", nm, 0);
  endtask

  task automatic t_flush();
    acc(0, 32'h0000_0000, 8'h06, 0, rd, lat, nm);
    chk("R8 flush latency", lat, 18);
    chk("R8 flush no memory", nm, 0);
    acc(0, 32'h0000_0054, 8'h0E, 0, rd, lat, nm);
    chk("R8 valid cleared", {31'b0, rd[31]}, 0);
    acc(0, A, 8'h08, 0, rd, lat, nm);
    chk("R8 line gone", nm, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_normal();
    t_upper();
    t_map();
    t_lru();
    t_forced();
    t_update();
    t_store();
    t_diag();
    t_nop();
    t_flush();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule